// File: doc/BRIEF.md
# Version String Fetch Sequencer

This block pulls a zero-terminated ASCII identification string out of a vendor register that sits behind a register-access port. Typically, an SPI transaction master serves that port. A single `start` pulse launches the sequence. The block first writes one byte to the register, which rewinds the device's internal string pointer. It then reads the same register four bytes at a time and stores the characters in a local buffer. It stops when a zero byte appears anywhere in a chunk, or when the length cap is reached.

The register address is formed from a fixed base and the locality number given with `start`. When the sequence ends, the block raises `done` for one cycle and reports the number of stored characters. The buffer can then be read one character per index. An error response from the register port ends the sequence early. In that case the block keeps the characters already stored and raises an error flag. SPI framing and any meaning of the string lie outside this block.

Top module: `verstr_fetch`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `reg_req` and `fail` are 0, `str_len` is 0, and every buffer index reads 0.
- R2: Every register transaction of a sequence uses the address 0x0F90 ORed with the locality shifted left by 12, where the locality is the value of `loc` sampled with the accepted `start`.
- R3: The first transaction of a sequence is a write (`reg_write`=1) of one byte (`reg_nbytes`=1) with `reg_wdata` equal to 0. No later transaction of the same sequence is a write.
- R4: Every transaction after the first is a four-byte read (`reg_write`=0, `reg_nbytes`=4). The character that comes first in the string is taken from `reg_rdata[7:0]`, and the following characters from successively higher bytes.
- R5: Within a chunk, bytes are stored in order up to the first zero byte. That zero ends the string, and `str_len` counts the stored characters.
- R6: Another read is issued only if the previous chunk held four non-zero bytes and fewer than 64 characters are stored. The length never exceeds 64.
- R7: After a sequence, `rd_char` at index i < `str_len` returns the i-th stored character. Index `str_len` returns 0, as does any index above 64.
- R8: An error response (`reg_err`) ends the sequence. `fail` is then set and `str_len` holds the characters stored before the failing transaction. `fail` is cleared by the next accepted start.
- R9: `busy` is high from the cycle after an accepted start until `done`. `done` is a single-cycle pulse, one per sequence, after which `busy` is 0.
- R10: A `start` pulse while `busy` is high is ignored: the address and the number of transactions are unchanged.
- R11: `reg_req` stays high, with a stable address and direction, until `reg_ack` or `reg_err` completes the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| loc | input | 4 | Locality number, sampled with start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| fail | output | 1 | Last sequence ended on an error response |
| str_len | output | 7 | Number of stored characters |
| rd_idx | input | 7 | Buffer read index |
| rd_char | output | 8 | Character at rd_idx |
| reg_req | output | 1 | Register transaction request |
| reg_write | output | 1 | 1 for write, 0 for read |
| reg_addr | output | 16 | Register address |
| reg_nbytes | output | 3 | Transaction size in bytes |
| reg_wdata | output | 8 | Write data byte |
| reg_ack | input | 1 | Transaction completed |
| reg_err | input | 1 | Transaction failed |
| reg_rdata | input | 32 | Read data, first character in bits 7:0 |

## Verification
A corrupted length counter or write pointer shows at the ports as soon as the sequence ends. The stored characters land at shifted indices, or the terminator moves, so readback after `done` mismatches. A wrong stop decision shows within one transaction: the register model counts one read too many or too few for the string it serves. A stale or mis-latched locality shows on `reg_addr` in the very first transaction. A lost error path shows as `fail` missing, or as further requests after the rejected one.

// File: rtl/verstr_pkg.sv
package verstr_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_REWIND = 2'd1,
      ST_FETCH = 2'd2,
      ST_CLOSE = 2'd3
   } seq_state_t;

   localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/verstr_scan.sv
// Splits one read word into ordered characters and counts the leading
// non-zero ones.
module verstr_scan
   import verstr_pkg::*;
#(
   parameter int unsigned CHUNK     = 4,
   parameter bit          FIRST_LOW = 1'b1,
   localparam int unsigned CNT_W    = $clog2(CHUNK + 1)
) (
   input  logic [CHUNK*BYTE_W-1:0]          word_in,
   output logic [CHUNK-1:0][BYTE_W-1:0]     chars,
   output logic [CNT_W-1:0]                 lead_cnt,
   output logic                             all_set
);
   logic [CHUNK-1:0] nonzero;

   for (genvar i = 0; i < CHUNK; i++) begin : g_lane
      if (FIRST_LOW) begin : g_low
         assign chars[i] = word_in[i*BYTE_W +: BYTE_W];
      end else begin : g_high
         assign chars[i] = word_in[(CHUNK-1-i)*BYTE_W +: BYTE_W];
      end
      assign nonzero[i] = |chars[i];
   end

   always_comb begin
      logic run;
      run      = 1'b1;
      lead_cnt = '0;
      for (int i = 0; i < CHUNK; i++) begin
         if (run && nonzero[i]) lead_cnt = lead_cnt + 1'b1;
         else                   run      = 1'b0;
      end
   end

   assign all_set = (lead_cnt == CNT_W'(CHUNK));
endmodule

// File: rtl/verstr_store.sv
// Character buffer: a chunk write of up to CHUNK characters at a base
// index, a terminator write, and an indexed read.
module verstr_store
   import verstr_pkg::*;
#(
   parameter int unsigned CHUNK   = 4,
   parameter int unsigned MAX_LEN = 64,
   localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1),
   localparam int unsigned CNT_W  = $clog2(CHUNK + 1),
   localparam int unsigned LANE_W = $clog2(CHUNK),
   localparam int unsigned DEPTH  = MAX_LEN + 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          chunk_we,
   input  logic                          term_we,
   input  logic [LEN_W-1:0]              base_idx,
   input  logic [CNT_W-1:0]              chunk_cnt,
   input  logic [CHUNK-1:0][BYTE_W-1:0]  chunk_chars,
   input  logic [LEN_W-1:0]              rd_idx,
   output logic [BYTE_W-1:0]             rd_char
);
   logic [DEPTH-1:0][BYTE_W-1:0] cells;

   for (genvar j = 0; j < DEPTH; j++) begin : g_cell
      logic [LEN_W:0] offs;
      logic           in_chunk;
      assign offs     = (LEN_W+1)'(j) - {1'b0, base_idx};
      assign in_chunk = ((LEN_W+1)'(j) >= {1'b0, base_idx}) &&
                        (offs < (LEN_W+1)'(chunk_cnt));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cells[j] <= '0;
         end else if (term_we && (base_idx == LEN_W'(j))) begin
            cells[j] <= '0;
         end else if (chunk_we && in_chunk) begin
            cells[j] <= chunk_chars[offs[LANE_W-1:0]];
         end
      end
   end

   always_comb begin
      rd_char = '0;
      for (int j = 0; j < DEPTH; j++) begin
         if (rd_idx == LEN_W'(j)) rd_char = cells[j];
      end
   end
endmodule

// File: rtl/verstr_ctrl.sv
// Sequence control: rewind write, chunk reads, stop decision, error abort.
module verstr_ctrl
   import verstr_pkg::*;
#(
   parameter int unsigned CHUNK     = 4,
   parameter int unsigned MAX_LEN   = 64,
   parameter int unsigned LOC_W     = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned LOC_SHIFT = 12,
   parameter logic [15:0] BASE_ADDR = 16'h0F90,
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1),
   localparam int unsigned CNT_W    = $clog2(CHUNK + 1),
   localparam int unsigned NB_W     = $clog2(CHUNK + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LOC_W-1:0]   loc,
   input  logic               bus_ack,
   input  logic               bus_err,
   input  logic [CNT_W-1:0]   scan_cnt,
   input  logic               scan_full,
   output logic               bus_req,
   output logic               bus_write,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic [NB_W-1:0]    bus_nbytes,
   output logic [LEN_W-1:0]   len,
   output logic               busy,
   output logic               done,
   output logic               fail,
   output logic               chunk_we,
   output logic               term_we
);
   seq_state_t        state;
   logic [LOC_W-1:0]  loc_q;
   logic [LEN_W-1:0]  len_q;
   logic              fail_q;
   logic [LEN_W:0]    len_sum;
   logic              more;

   assign len_sum = {1'b0, len_q} + (LEN_W+1)'(scan_cnt);
   assign more    = scan_full && (len_sum < (LEN_W+1)'(MAX_LEN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         loc_q  <= '0;
         len_q  <= '0;
         fail_q <= 1'b0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state  <= ST_REWIND;
                  loc_q  <= loc;
                  len_q  <= '0;
                  fail_q <= 1'b0;
               end
            end
            ST_REWIND: begin
               if (bus_err) begin
                  state  <= ST_CLOSE;
                  fail_q <= 1'b1;
               end else if (bus_ack) begin
                  state <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (bus_err) begin
                  state  <= ST_CLOSE;
                  fail_q <= 1'b1;
               end else if (bus_ack) begin
                  len_q <= len_sum[LEN_W-1:0];
                  if (!more) state <= ST_CLOSE;
               end
            end
            ST_CLOSE: state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign bus_req    = (state == ST_REWIND) || (state == ST_FETCH);
   assign bus_write  = (state == ST_REWIND);
   assign bus_nbytes = (state == ST_REWIND) ? NB_W'(1) : NB_W'(CHUNK);
   assign bus_addr   = ADDR_W'(BASE_ADDR) | (ADDR_W'(loc_q) << LOC_SHIFT);
   assign len        = len_q;
   assign busy       = (state != ST_IDLE);
   assign done       = (state == ST_CLOSE);
   assign fail       = fail_q;
   assign chunk_we   = (state == ST_FETCH) && bus_ack && !bus_err;
   assign term_we    = (state == ST_CLOSE);

   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack && !bus_err) |=> (bus_req && $stable(bus_addr) && $stable(bus_write)));

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(loc_q));

   // R8
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_err) |=> (done && fail && !bus_req));

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!busy && !done));

   // R6
   len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (len <= LEN_W'(MAX_LEN)));

   // R3
   write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_write) |-> (len == '0 && bus_nbytes == NB_W'(1)));
endmodule

// File: rtl/verstr_fetch.sv
module verstr_fetch
   import verstr_pkg::*;
#(
   parameter int unsigned CHUNK     = 4,
   parameter int unsigned MAX_LEN   = 64,
   parameter int unsigned LOC_W     = 4,
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned LOC_SHIFT = 12,
   parameter logic [15:0] BASE_ADDR = 16'h0F90,
   parameter bit          FIRST_LOW = 1'b1,
   localparam int unsigned LEN_W    = $clog2(MAX_LEN + 1),
   localparam int unsigned NB_W     = $clog2(CHUNK + 1),
   localparam int unsigned CNT_W    = $clog2(CHUNK + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic [LOC_W-1:0]         loc,
   output logic                     busy,
   output logic                     done,
   output logic                     fail,
   output logic [LEN_W-1:0]         str_len,
   input  logic [LEN_W-1:0]         rd_idx,
   output logic [7:0]               rd_char,
   output logic                     reg_req,
   output logic                     reg_write,
   output logic [ADDR_W-1:0]        reg_addr,
   output logic [NB_W-1:0]          reg_nbytes,
   output logic [7:0]               reg_wdata,
   input  logic                     reg_ack,
   input  logic                     reg_err,
   input  logic [CHUNK*8-1:0]       reg_rdata
);
   if (CHUNK < 2) begin : g_bad_chunk
      $error("CHUNK must be at least 2");
   end
   if ((MAX_LEN % CHUNK) != 0) begin : g_bad_cap
      $error("MAX_LEN must be a multiple of CHUNK");
   end
   if ((LOC_SHIFT + LOC_W) > ADDR_W) begin : g_bad_loc
      $error("locality field does not fit the address");
   end

   logic [CHUNK-1:0][BYTE_W-1:0] chars;
   logic [CNT_W-1:0]             scan_cnt;
   logic                         scan_full;
   logic                         chunk_we;
   logic                         term_we;

   verstr_scan #(.CHUNK(CHUNK), .FIRST_LOW(FIRST_LOW)) u_scan (
      .word_in  (reg_rdata),
      .chars    (chars),
      .lead_cnt (scan_cnt),
      .all_set  (scan_full)
   );

   verstr_ctrl #(
      .CHUNK(CHUNK), .MAX_LEN(MAX_LEN), .LOC_W(LOC_W), .ADDR_W(ADDR_W),
      .LOC_SHIFT(LOC_SHIFT), .BASE_ADDR(BASE_ADDR)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .loc        (loc),
      .bus_ack    (reg_ack),
      .bus_err    (reg_err),
      .scan_cnt   (scan_cnt),
      .scan_full  (scan_full),
      .bus_req    (reg_req),
      .bus_write  (reg_write),
      .bus_addr   (reg_addr),
      .bus_nbytes (reg_nbytes),
      .len        (str_len),
      .busy       (busy),
      .done       (done),
      .fail       (fail),
      .chunk_we   (chunk_we),
      .term_we    (term_we)
   );

   verstr_store #(.CHUNK(CHUNK), .MAX_LEN(MAX_LEN)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .chunk_we    (chunk_we),
      .term_we     (term_we),
      .base_idx    (str_len),
      .chunk_cnt   (scan_cnt),
      .chunk_chars (chars),
      .rd_idx      (rd_idx),
      .rd_char     (rd_char)
   );

   assign reg_wdata = 8'h00;

   // R7
   term_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rd_idx > LEN_W'(MAX_LEN)) |-> (rd_char == 8'h00));
endmodule

// File: tb/verstr_fetch_bench.sv
`timescale 1ns/1ps
module verstr_fetch_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  loc = '0;
   logic        busy, done, fail;
   logic [6:0]  str_len;
   logic [6:0]  rd_idx = '0;
   logic [7:0]  rd_char;
   logic        reg_req, reg_write;
   logic [15:0] reg_addr;
   logic [2:0]  reg_nbytes;
   logic [7:0]  reg_wdata;
   logic        reg_ack = 1'b0;
   logic        reg_err = 1'b0;
   logic [31:0] reg_rdata = '0;

   always #4 clk = ~clk;

   verstr_fetch u_verstr_fetch (
      .clk(clk), .rst_n(rst_n), .start(start), .loc(loc),
      .busy(busy), .done(done), .fail(fail), .str_len(str_len),
      .rd_idx(rd_idx), .rd_char(rd_char),
      .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
      .reg_nbytes(reg_nbytes), .reg_wdata(reg_wdata),
      .reg_ack(reg_ack), .reg_err(reg_err), .reg_rdata(reg_rdata)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // register model: string memory with a read pointer
   byte unsigned mem [0:127];
   int ptr = 0;
   int txn_no = 0;
   int err_at = 0;
   int slave_lat = 0;
   int lat_cnt = 0;
   int exp_addr = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_ack || reg_err) begin
            reg_ack = 1'b0;
            reg_err = 1'b0;
         end else if (reg_req) begin
            if (lat_cnt < slave_lat) begin
               lat_cnt++;
            end else begin
               lat_cnt = 0;
               txn_no++;
               check(int'(reg_addr) == exp_addr, "R2 address", int'(reg_addr), exp_addr);
               check(reg_write == (txn_no == 1), "R3 direction", int'(reg_write), int'(txn_no == 1));
               if (reg_write) begin
                  check(reg_nbytes == 3'd1 && reg_wdata == 8'h00, "R3 write size/data",
                        int'(reg_nbytes), 1);
               end else begin
                  check(reg_nbytes == 3'd4, "R4 read size", int'(reg_nbytes), 4);
               end
               if (txn_no == err_at) begin
                  reg_err = 1'b1;
               end else begin
                  reg_ack = 1'b1;
                  if (reg_write) ptr = 0;
                  else begin
                     for (int i = 0; i < 4; i++)
                        reg_rdata[i*8 +: 8] = (ptr + i < 128) ? mem[ptr + i] : 8'h00;
                     ptr += 4;
                  end
               end
            end
         end else begin
            lat_cnt = 0;
         end
      end
   end

   task automatic fill_str(input string s);
      for (int i = 0; i < 128; i++) mem[i] = 8'h00;
      for (int i = 0; i < s.len() && i < 128; i++) mem[i] = s[i];
   endtask

   task automatic fill_pattern(input int n);
      for (int i = 0; i < 128; i++) mem[i] = (i < n) ? 8'(8'h41 + (i % 26)) : 8'h00;
   endtask

   // one sequence; poke = second start while busy (R10)
   task automatic run_seq(input int l, input int err_i, input bit poke, input string tag);
      int e_len, e_txn, p, cnt, cyc, dones;
      bit e_fail, stop;
      // behavioural expectation
      e_len = 0; e_fail = 0; e_txn = 1; p = 0;
      if (err_i == 1) e_fail = 1;
      else begin
         stop = 0;
         while (!stop) begin
            e_txn++;
            if (e_txn == err_i) begin e_fail = 1; stop = 1; end
            else begin
               cnt = 0;
               for (int i = 0; i < 4; i++) begin
                  if (mem[p+i] == 0) break;
                  cnt++;
               end
               e_len += cnt; p += 4;
               if (cnt < 4 || e_len >= 64) stop = 1;
            end
         end
      end
      err_at = err_i; txn_no = 0; ptr = 20;
      exp_addr = 16'h0F90 | (l << 12);
      @(negedge clk);
      start = 1'b1; loc = 4'(l);
      @(negedge clk);
      start = 1'b0;
      cyc = 0; dones = 0;
      while (dones == 0 && cyc < 2000) begin
         if (poke && cyc == 2) begin start = 1'b1; loc = 4'd5; end
         else start = 1'b0;
         if (done) dones++;
         else check(busy == 1'b1, "R9 busy during sequence", int'(busy), 1);
         if (dones == 0) @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      check(cyc < 2000, {"R9 watchdog ", tag}, cyc, 0);
      @(negedge clk);
      check(!done && !busy, {"R9 done single pulse ", tag}, int'(done), 0);
      check(int'(str_len) == e_len, {"R5/R6 length ", tag}, int'(str_len), e_len);
      check(fail == e_fail, {"R8 fail flag ", tag}, int'(fail), int'(e_fail));
      check(txn_no == e_txn, {"R6/R10 transaction count ", tag}, txn_no, e_txn);
      for (int i = 0; i < e_len; i++) begin
         rd_idx = 7'(i); #1;
         check(rd_char == mem[i], {"R4/R7 char ", tag}, int'(rd_char), int'(mem[i]));
      end
      rd_idx = 7'(e_len); #1;
      check(rd_char == 8'h00, {"R7 terminator ", tag}, int'(rd_char), 0);
      rd_idx = 7'd100; #1;
      check(rd_char == 8'h00, {"R7 out of range ", tag}, int'(rd_char), 0);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) mem[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      check(!busy && !done && !reg_req && !fail, "R1 idle after reset", int'(busy), 0);
      check(str_len == 0, "R1 length after reset", int'(str_len), 0);
      rd_idx = 7'd3; #1;
      check(rd_char == 0, "R1 buffer after reset", int'(rd_char), 0);

      fill_str("fw_1.2.3");  run_seq(0, 0, 0, "eight");
      fill_str("ver-0.9");   run_seq(1, 0, 0, "seven");
      slave_lat = 2;
      fill_str("abc");       run_seq(2, 0, 0, "three_slow");
      slave_lat = 0;
      fill_str("");          run_seq(0, 0, 0, "empty");
      fill_pattern(70);      run_seq(3, 0, 0, "cap70");
      fill_pattern(64);      run_seq(15, 0, 0, "cap64");
      fill_pattern(20);      run_seq(4, 3, 0, "err_read");
      fill_pattern(20);      run_seq(6, 1, 0, "err_write");
      fill_str("ok");        run_seq(7, 0, 0, "after_err");
      fill_pattern(30);      run_seq(9, 0, 1, "start_busy");

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule